// File: doc/BRIEF.md
# LCD Window Output Timing Generator

This block scans a full CIF raster (352 pixels by 288 lines by default) and shows only a 176 by 220 window of it on an LCD. The window can be moved anywhere inside the raster. Every raster position outside the window is sent as black. The block drives active-low line and frame syncs. It also drives a frame-level valid flag that covers the window lines and a pixel-level valid flag that covers the window pixels. A clock enable follows the window and runs on for a fixed number of pixels after the pixel-valid flag drops.

The block advances one raster position per clock, so the system clock is the pixel rate. At the default size, a clock of about 6.1 MHz gives 60 frames per second. Inside the window the block raises `pix_req` to ask the upstream stream for a pixel. The RGB word offered on `pix_in` in that same cycle appears on `lcd_rgb` one cycle later, together with `lcd_hvalid`. Outputs change on the rising system edge. The external pixel clock is meant to be the inverse of the gated clock, so the data changes on its falling edge. The horizontal and vertical window positions are plain inputs. The block reads them only when the raster is at its first pixel.

Top module: `lcd_window_timing`

## Requirements
- R1: `lcd_hsync_n` is low for the first HSYNC_W pixels of every line and high for the rest of the line. A line lasts H_TOTAL clocks.
- R2: `lcd_vsync_n` is low for every pixel of the first VSYNC_W lines of a frame and high on all other lines. A frame lasts V_TOTAL lines.
- R3: `lcd_vvalid` is high for every pixel of lines vp to vp+WIN_H-1, where vp is the frame's vertical position, and low on all other lines.
- R4: `lcd_hvalid` is high exactly on pixels hp to hp+WIN_W-1 of the lines where `lcd_vvalid` is high, where hp is the frame's horizontal position.
- R5: On a pixel where `lcd_hvalid` is high, `lcd_rgb` carries the `pix_in` word offered in the previous cycle, passed through unchanged. On every other pixel `lcd_rgb` is all zeros (black).
- R6: `lcd_pclk_en` is high on window lines from pixel hp up to and including pixel hp+WIN_W+CLK_TAIL-1, limited by the end of the line. It is low everywhere else.
- R7: The positions are read from `hpos` and `vpos` only in the cycle in which the raster sits at pixel 0 of line 0. A change at any other time first takes effect in the next frame.
- R8: A horizontal position above H_TOTAL-WIN_W is used as H_TOTAL-WIN_W. A vertical position above V_TOTAL-WIN_H is used as V_TOTAL-WIN_H. The window therefore always lies fully inside the raster.
- R9: `pix_req` is high, combinationally, in exactly the cycles whose raster position lies inside the window. It leads `lcd_hvalid` by one cycle.
- R10: While `rst` is high, at the next rising edge both syncs go high, the valid flags and the clock enable go low, and `lcd_rgb` goes to zero. The first clock after `rst` falls emits pixel 0 of line 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel-rate clock |
| rst | input | 1 | Synchronous reset, active high |
| hpos | input | $clog2(H_TOTAL) | Requested horizontal window start, in pixels |
| vpos | input | $clog2(V_TOTAL) | Requested vertical window start, in lines |
| pix_in | input | 3*CH_W | Upstream RGB word, red in the top CH_W bits, blue in the bottom |
| pix_req | output | 1 | Upstream pixel request for the current cycle |
| lcd_vsync_n | output | 1 | Frame sync, active low |
| lcd_hsync_n | output | 1 | Line sync, active low |
| lcd_vvalid | output | 1 | Window-line valid flag |
| lcd_hvalid | output | 1 | Window-pixel valid flag |
| lcd_pclk_en | output | 1 | Enable for the gated output pixel clock |
| lcd_rgb | output | 3*CH_W | Output RGB word, black outside the window |

## Verification
The bench builds the block with a 16 by 12 raster, a 6 by 5 window, 2-pixel line sync, 1-line frame sync and a 2-pixel clock tail. With these values a whole frame takes 192 clocks, so every frame edge and every window edge is crossed many times. The largest legal positions (10 and 7) can be placed exactly, and the 4-bit position inputs can request 15 and 11, which the clamp must cut back. A 2-pixel tail placed at the largest horizontal position runs past the line end, which exercises the case where the tail is cut off at the line boundary.

// File: rtl/lcdw_pkg.sv
package lcdw_pkg;
  // Per-position decode shared between the window compare and the output registers.
  typedef struct packed {
    logic in_line;   // line inside the window
    logic in_pix;    // pixel inside the window (line and column)
    logic in_clk;    // inside the gated-clock span
    logic hs_act;    // line sync active
    logic vs_act;    // frame sync active
  } lcdw_dec_t;
endpackage

// File: rtl/lcdw_raster.sv
module lcdw_raster #(
  parameter int H_TOTAL = 352,
  parameter int V_TOTAL = 288,
  localparam int HW = $clog2(H_TOTAL),
  localparam int VW = $clog2(V_TOTAL)
) (
  input  logic          clk,
  input  logic          rst,
  output logic [HW-1:0] hcnt,
  output logic [VW-1:0] vcnt,
  output logic          frame_start
);
  localparam logic [HW-1:0] H_LAST = HW'(H_TOTAL - 1);
  localparam logic [VW-1:0] V_LAST = VW'(V_TOTAL - 1);

  always_ff @(posedge clk) begin
    if (rst) begin
      hcnt <= '0;
      vcnt <= '0;
    end else if (hcnt == H_LAST) begin
      hcnt <= '0;
      vcnt <= (vcnt == V_LAST) ? '0 : vcnt + 1'b1;
    end else begin
      hcnt <= hcnt + 1'b1;
    end
  end

  assign frame_start = (hcnt == '0) && (vcnt == '0);

  AST_HCNT_WRAP: assert property (@(posedge clk) disable iff (rst) (hcnt == H_LAST) |=> (hcnt == '0)); // R1
  AST_VCNT_HOLD: assert property (@(posedge clk) disable iff (rst) (hcnt != H_LAST) |=> $stable(vcnt)); // R2
endmodule

// File: rtl/lcdw_window.sv
module lcdw_window #(
  parameter int TOTAL = 352,
  parameter int SPAN  = 176,
  localparam int PW = $clog2(TOTAL)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          frame_start,
  input  logic [PW-1:0] pos_in,
  output logic [PW-1:0] pos_eff
);
  localparam logic [PW-1:0] MAX_POS = PW'(TOTAL - SPAN);

  logic [PW-1:0] pos_clamp;
  logic [PW-1:0] pos_lat;

  assign pos_clamp = (pos_in > MAX_POS) ? MAX_POS : pos_in;

  always_ff @(posedge clk) begin
    if (rst)              pos_lat <= '0;
    else if (frame_start) pos_lat <= pos_clamp;
  end

  // The first pixel of a frame already uses the freshly sampled position.
  assign pos_eff = frame_start ? pos_clamp : pos_lat;

  AST_POS_CLAMP: assert property (@(posedge clk) disable iff (rst) pos_eff <= MAX_POS); // R8
  AST_POS_HOLD: assert property (@(posedge clk) disable iff (rst) !frame_start |=> $stable(pos_lat)); // R7
endmodule

// File: rtl/lcdw_out.sv
module lcdw_out
  import lcdw_pkg::*;
#(
  parameter int H_TOTAL   = 352,
  parameter int V_TOTAL   = 288,
  parameter int WIN_W     = 176,
  parameter int WIN_H     = 220,
  parameter int HSYNC_W   = 16,
  parameter int VSYNC_W   = 2,
  parameter int CLK_TAIL  = 4,
  parameter int CH_W      = 6,
  localparam int HW  = $clog2(H_TOTAL),
  localparam int VW  = $clog2(V_TOTAL),
  localparam int HXW = HW + 2,
  localparam int VXW = VW + 2,
  localparam int PXW = 3 * CH_W
) (
  input  logic           clk,
  input  logic           rst,
  input  logic [HW-1:0]  hcnt,
  input  logic [VW-1:0]  vcnt,
  input  logic [HW-1:0]  hpos_eff,
  input  logic [VW-1:0]  vpos_eff,
  input  logic [PXW-1:0] pix_in,
  output logic           pix_req,
  output logic           vsync_n,
  output logic           hsync_n,
  output logic           vvalid,
  output logic           hvalid,
  output logic           pclk_en,
  output logic [PXW-1:0] rgb
);
  localparam logic [HXW-1:0] WIN_W_X = HXW'(WIN_W);
  localparam logic [HXW-1:0] TAIL_X  = HXW'(CLK_TAIL);
  localparam logic [VXW-1:0] WIN_H_X = VXW'(WIN_H);
  localparam logic [HW-1:0]  HS_END  = HW'(HSYNC_W);
  localparam logic [VW-1:0]  VS_END  = VW'(VSYNC_W);

  logic [HXW-1:0] hx, hp;
  logic [VXW-1:0] vx, vp;
  lcdw_dec_t      dec;

  assign hx = HXW'(hcnt);
  assign hp = HXW'(hpos_eff);
  assign vx = VXW'(vcnt);
  assign vp = VXW'(vpos_eff);

  always_comb begin
    dec.in_line = (vx >= vp) && (vx < vp + WIN_H_X);
    dec.in_pix  = dec.in_line && (hx >= hp) && (hx < hp + WIN_W_X);
    dec.in_clk  = dec.in_line && (hx >= hp) && (hx < hp + WIN_W_X + TAIL_X);
    dec.hs_act  = (hcnt < HS_END);
    dec.vs_act  = (vcnt < VS_END);
  end

  assign pix_req = dec.in_pix;

  always_ff @(posedge clk) begin
    if (rst) begin
      vsync_n <= 1'b1;
      hsync_n <= 1'b1;
      vvalid  <= 1'b0;
      hvalid  <= 1'b0;
      pclk_en <= 1'b0;
      rgb     <= '0;
    end else begin
      vsync_n <= !dec.vs_act;
      hsync_n <= !dec.hs_act;
      vvalid  <= dec.in_line;
      hvalid  <= dec.in_pix;
      pclk_en <= dec.in_clk;
      rgb     <= dec.in_pix ? pix_in : '0;
    end
  end

  AST_BLACK_OUTSIDE: assert property (@(posedge clk) disable iff (rst) !hvalid |-> (rgb == '0)); // R5
  AST_PIX_IN_LINE: assert property (@(posedge clk) disable iff (rst) hvalid |-> vvalid); // R4
  AST_CLK_COVERS: assert property (@(posedge clk) disable iff (rst) hvalid |-> pclk_en); // R6
  AST_REQ_LEADS: assert property (@(posedge clk) disable iff (rst) pix_req |=> hvalid); // R9
endmodule

// File: rtl/lcd_window_timing.sv
module lcd_window_timing #(
  parameter int H_TOTAL  = 352,
  parameter int V_TOTAL  = 288,
  parameter int WIN_W    = 176,
  parameter int WIN_H    = 220,
  parameter int HSYNC_W  = 16,
  parameter int VSYNC_W  = 2,
  parameter int CLK_TAIL = 4,
  parameter int CH_W     = 6,
  localparam int HW  = $clog2(H_TOTAL),
  localparam int VW  = $clog2(V_TOTAL),
  localparam int PXW = 3 * CH_W
) (
  input  logic           clk,
  input  logic           rst,
  input  logic [HW-1:0]  hpos,
  input  logic [VW-1:0]  vpos,
  input  logic [PXW-1:0] pix_in,
  output logic           pix_req,
  output logic           lcd_vsync_n,
  output logic           lcd_hsync_n,
  output logic           lcd_vvalid,
  output logic           lcd_hvalid,
  output logic           lcd_pclk_en,
  output logic [PXW-1:0] lcd_rgb
);
  logic [HW-1:0] hcnt, hpos_eff;
  logic [VW-1:0] vcnt, vpos_eff;
  logic          frame_start;

  lcdw_raster #(.H_TOTAL(H_TOTAL), .V_TOTAL(V_TOTAL)) u_raster (
    .clk(clk), .rst(rst), .hcnt(hcnt), .vcnt(vcnt), .frame_start(frame_start)
  );

  lcdw_window #(.TOTAL(H_TOTAL), .SPAN(WIN_W)) u_hwin (
    .clk(clk), .rst(rst), .frame_start(frame_start), .pos_in(hpos), .pos_eff(hpos_eff)
  );

  lcdw_window #(.TOTAL(V_TOTAL), .SPAN(WIN_H)) u_vwin (
    .clk(clk), .rst(rst), .frame_start(frame_start), .pos_in(vpos), .pos_eff(vpos_eff)
  );

  lcdw_out #(
    .H_TOTAL(H_TOTAL), .V_TOTAL(V_TOTAL), .WIN_W(WIN_W), .WIN_H(WIN_H),
    .HSYNC_W(HSYNC_W), .VSYNC_W(VSYNC_W), .CLK_TAIL(CLK_TAIL), .CH_W(CH_W)
  ) u_out (
    .clk(clk), .rst(rst), .hcnt(hcnt), .vcnt(vcnt),
    .hpos_eff(hpos_eff), .vpos_eff(vpos_eff), .pix_in(pix_in),
    .pix_req(pix_req), .vsync_n(lcd_vsync_n), .hsync_n(lcd_hsync_n),
    .vvalid(lcd_vvalid), .hvalid(lcd_hvalid), .pclk_en(lcd_pclk_en), .rgb(lcd_rgb)
  );
endmodule

// File: tb/lcd_window_timing_bench.sv
`timescale 1ns/1ps
module lcd_window_timing_bench;
  localparam int HT = 16, VT = 12, WW = 6, WH = 5, HS = 2, VS = 1, TAIL = 2, CH = 6;
  localparam int HMAX = HT - WW, VMAX = VT - WH;
  localparam int FRAME = HT * VT;
  localparam int NTAB = 6;
  localparam int TAB [NTAB][2] = '{'{0, 0}, '{1, 1}, '{10, 7}, '{15, 11}, '{3, 2}, '{12, 4}};

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic        rst;
  logic [3:0]  hpos, vpos;
  logic [17:0] pix_in;
  logic        pix_req, vs_n, hs_n, vval, hval, pce;
  logic [17:0] rgb;

  lcd_window_timing #(
    .H_TOTAL(HT), .V_TOTAL(VT), .WIN_W(WW), .WIN_H(WH),
    .HSYNC_W(HS), .VSYNC_W(VS), .CLK_TAIL(TAIL), .CH_W(CH)
  ) u_lcd_window_timing (
    .clk(clk), .rst(rst), .hpos(hpos), .vpos(vpos), .pix_in(pix_in),
    .pix_req(pix_req), .lcd_vsync_n(vs_n), .lcd_hsync_n(hs_n),
    .lcd_vvalid(vval), .lcd_hvalid(hval), .lcd_pclk_en(pce), .lcd_rgb(rgb)
  );

  int n_chk = 0, n_fail = 0;
  int cx, cy, fhp, fvp;
  bit done = 0;

  function automatic int clampi(int v, int m);
    return (v > m) ? m : v;
  endfunction

  task automatic chk(bit ok, string req, int act, int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d (x=%0d y=%0d)", req, act, exp, cx, cy);
    end
  endtask

  // One clock: predict the pixel emitted by the next edge, then compare at the falling edge.
  task automatic step(string ctx);
    int vx, vy, vhp, vvp, ph, pv;
    bit inl, inp, inc;
    logic [17:0] vpix;
    if (cx == 0 && cy == 0) begin
      fhp = clampi(int'(hpos), HMAX);
      fvp = clampi(int'(vpos), VMAX);
    end
    vx = cx; vy = cy; vhp = fhp; vvp = fvp; vpix = pix_in;
    @(posedge clk);
    @(negedge clk);
    cx++;
    if (cx == HT) begin cx = 0; cy = (cy == VT - 1) ? 0 : cy + 1; end
    inl = (vy >= vvp) && (vy < vvp + WH);
    inp = inl && (vx >= vhp) && (vx < vhp + WW);
    inc = inl && (vx >= vhp) && (vx < vhp + WW + TAIL);
    chk(hs_n == !(vx < HS), {"R1 hsync ", ctx}, int'(hs_n), int'(!(vx < HS)));
    chk(vs_n == !(vy < VS), {"R2 vsync ", ctx}, int'(vs_n), int'(!(vy < VS)));
    chk(vval == inl, {"R3 vvalid ", ctx}, int'(vval), int'(inl));
    chk(hval == inp, {"R4 hvalid ", ctx}, int'(hval), int'(inp));
    chk(rgb == (inp ? vpix : 18'd0), {"R5 rgb ", ctx}, int'(rgb), inp ? int'(vpix) : 0);
    chk(pce == inc, {"R6 pclk_en ", ctx}, int'(pce), int'(inc));
    if (cx == 0 && cy == 0) begin
      ph = clampi(int'(hpos), HMAX); pv = clampi(int'(vpos), VMAX);
    end else begin
      ph = fhp; pv = fvp;
    end
    inp = (cy >= pv) && (cy < pv + WH) && (cx >= ph) && (cx < ph + WW);
    chk(pix_req == inp, {"R9 pix_req ", ctx}, int'(pix_req), int'(inp));
    pix_in = pix_in + 18'd4133;
  endtask

  task automatic check_idle(string ctx);
    chk(vs_n == 1'b1, {"R10 vsync idle ", ctx}, int'(vs_n), 1);
    chk(hs_n == 1'b1, {"R10 hsync idle ", ctx}, int'(hs_n), 1);
    chk({vval, hval, pce} == 3'b000, {"R10 flags idle ", ctx}, int'({vval, hval, pce}), 0);
    chk(rgb == 18'd0, {"R10 rgb idle ", ctx}, int'(rgb), 0);
  endtask

  task automatic to_frame_start(string ctx);
    while (!(cx == 0 && cy == 0)) step(ctx);
  endtask

  task automatic run_frame(string ctx);
    for (int i = 0; i < FRAME; i++) step(ctx);
  endtask

  initial begin
    rst = 1'b1; hpos = '0; vpos = '0; pix_in = 18'h15A5A;
    repeat (3) @(negedge clk);
    check_idle("power-on");
    rst = 1'b0; cx = 0; cy = 0; fhp = 0; fvp = 0;
    run_frame("R10 first frame after reset");

    // Table walk: program a position mid-frame, then check a whole frame at it (R8 on clamped rows).
    for (int t = 0; t < NTAB; t++) begin
      repeat (37) step("table lead-in");
      hpos = 4'(TAB[t][0]); vpos = 4'(TAB[t][1]);
      to_frame_start("R7 old position until frame start");
      run_frame((TAB[t][0] > HMAX || TAB[t][1] > VMAX) ? "R8 clamped position" : "table position");
    end

    // R7: change the position in the middle of a frame; the window must not move until the next frame.
    hpos = 4'd2; vpos = 4'd1;
    to_frame_start("R7 setup");
    repeat (FRAME / 2) step("R7 first half");
    hpos = 4'd9; vpos = 4'd6;
    to_frame_start("R7 mid-frame change ignored");
    run_frame("R7 new position in next frame");

    // R10: reset in the middle of a frame, then restart at the first pixel.
    repeat (50) step("R10 lead-in");
    rst = 1'b1;
    @(negedge clk);
    check_idle("mid-frame");
    repeat (2) @(negedge clk);
    check_idle("held");
    hpos = 4'd4; vpos = 4'd3;
    rst = 1'b0; cx = 0; cy = 0;
    run_frame("R10 restart at pixel 0");

    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    #(200000 * 4);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule